// File: doc/BRIEF.md
# Clock Loss Supervisor

This block is the control half of a clocking subsystem. It watches four detector signals: reference present, PLL feedback present, PLL locked, and fallback oscillator alive. From these it decides which clock source the chip runs from. It holds the system in reset until the sources are usable. It gates the core clock while the chip is stopped, recovering or halted. It keeps sticky status flags for clock loss and lock loss. The clock detectors, the analog PLL and the glitch-free mux that acts on the mode output are outside the block.

After reset the block waits in a holding state. It leaves that state once the reference is present and, unless an external clock is strapped, the PLL is locked. While running from the PLL, a clock loss is handled in one of three ways: it raises a one-cycle reset request, it falls back to the self-clocked oscillator, or it halts. A fallback or a halt lasts until the next reset. When reference and PLL fail together, the block treats the event as a reference failure.

Stop mode gates the clock. On wake-up the block waits a bounded window for the sources to return. If the feedback clock never returns, the block halts. If the reference or lock stays missing, the block falls back regardless of the loss-enable bit, and the matching status flag is hidden until that signal is regained.

Top module: `clk_loss_supervisor`

## Requirements
- R1: While `rst_n` is low, and afterwards until the synchronized reference is present and the PLL is locked, `rst_hold_o` is 1 and `clk_gate_o` is 0. With `ext_sel_i` = 1, reference presence alone releases the hold.
- R2: `mode_o` encodes the source as follows: 2'b00 external clock, 2'b01 PLL, 2'b10 self-clocked fallback, 2'b11 halted. During the reset hold it shows 2'b00 if `ext_sel_i` is 1 and 2'b01 otherwise.
- R3: In PLL mode, a loss of the reference or the feedback clock has this effect when `loc_en_i` = 1, `loc_rst_en_i` = 0 and the fallback is alive: the mode becomes 2'b10, the clock stays enabled and `loc_flag_o` becomes 1. A simultaneous loss of both clocks gives the same result.
- R4: Once in self-clocked mode, the block stays there until reset, even after the reference and PLL return.
- R5: A clock loss in PLL mode with `loc_en_i` = 0, or with the fallback oscillator dead, makes the mode 2'b11 with `clk_gate_o` = 0. The block stays there until reset.
- R6: A loss in PLL mode with `loc_rst_en_i` = 1 raises `rst_req_o` for exactly one cycle and returns the block to the reset hold of R1. It does not fall back.
- R7: A lock loss in PLL mode with both clocks present sets `lock_flag_o`, and the mode stays 2'b01.
- R8: The flags are sticky. They are cleared one cycle after a pulse on `clr_loc_i` or `clr_lock_i`. A set condition present in the same cycle as the clear wins.
- R9: In external-clock mode, loss events leave the mode at 2'b00, and both flags read 0.
- R10: A pulse on `stop_req_i` in PLL mode gates the clock off. Detector changes during stop have no effect. After a pulse on `wake_i`, the clock is enabled in PLL mode again as soon as all three PLL-side detectors are good.
- R11: If the feedback clock is back but the reference or the lock is not, `WAKE_WAIT` cycles after the wake pulse the block enters mode 2'b10 whatever `loc_en_i` is.
- R12: After the recovery of R11, the loss flag stays 0 until the reference returns, and the lock flag stays 0 until lock returns. Each then reads 1.
- R13: If the feedback clock has not returned when the wake window ends, the mode becomes 2'b11.
- R14: A stop request in the same cycle as a detected clock loss is ignored, and the loss is handled as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock (always running) |
| rst_n | input | 1 | Active-low system reset |
| ref_ok_i | input | 1 | Reference present, asynchronous |
| fb_ok_i | input | 1 | PLL feedback clock present, asynchronous |
| lock_i | input | 1 | PLL locked, asynchronous |
| alt_ok_i | input | 1 | Fallback oscillator alive, asynchronous |
| ext_sel_i | input | 1 | External clock strap |
| loc_en_i | input | 1 | Allow fallback on clock loss |
| loc_rst_en_i | input | 1 | Request reset instead of fallback |
| stop_req_i | input | 1 | Stop-mode entry pulse |
| wake_i | input | 1 | Stop-mode exit pulse |
| clr_loc_i | input | 1 | Write-one-to-clear for loss flag |
| clr_lock_i | input | 1 | Write-one-to-clear for lock flag |
| mode_o | output | 2 | Selected clock source |
| clk_gate_o | output | 1 | Core clock enable |
| rst_hold_o | output | 1 | System held in reset |
| rst_req_o | output | 1 | One-cycle reset request |
| loc_flag_o | output | 1 | Sticky clock-loss status |
| lock_flag_o | output | 1 | Sticky lock-loss status |

## Verification
Two pairs of functions can meet in one cycle. The first pair is a flag clear strobe and a live set condition. The bench keeps the lock detector low while it pulses the clear, and expects the flag to stay 1. The second pair is a stop request and a clock loss seen by the controller in the same cycle. The bench drops the detectors and times the stop pulse two cycles later, so that both reach the controller on the same edge. It then expects fallback mode with the clock still enabled, not a gated stop.

// File: rtl/clk_sup_pkg.sv
package clk_sup_pkg;

    typedef enum logic [1:0] {
        MODE_EXT  = 2'b00,
        MODE_PLL  = 2'b01,
        MODE_SELF = 2'b10,
        MODE_HALT = 2'b11
    } mode_e;

    typedef enum logic [2:0] {
        ST_INIT,
        ST_EXT,
        ST_RUN,
        ST_SELF,
        ST_HALT,
        ST_STOP,
        ST_WAKE
    } state_e;

endpackage

// File: rtl/clk_sup_sync.sv
module clk_sup_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic [STAGES-1:0] sh_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= {sh_q[STAGES-2:0], d_i[i]};
        end
        assign q_o[i] = sh_q[STAGES-1];
    end

endmodule

// File: rtl/clk_sup_ctrl.sv
module clk_sup_ctrl
    import clk_sup_pkg::*;
#(
    parameter int WAKE_WAIT = 16
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   ref_s,
    input  logic   fb_s,
    input  logic   lock_s,
    input  logic   alt_s,
    input  logic   ext_sel,
    input  logic   loc_en,
    input  logic   loc_rst_en,
    input  logic   stop_req,
    input  logic   wake,
    output state_e state_o,
    output logic   rst_req_o,
    output logic   set_loc_o,
    output logic   set_lock_o,
    output logic   arm_clk_o,
    output logic   arm_lock_o
);

    localparam int CW = $clog2(WAKE_WAIT + 1);
    localparam logic [CW-1:0] LIMIT = CW'(WAKE_WAIT);

    typedef struct packed {
        state_e        st;
        logic [CW-1:0] cnt;
        logic          req;
    } ctrl_t;

    ctrl_t r_d, r_q;
    logic  clk_lost;

    always_comb begin
        r_d        = r_q;
        r_d.req    = 1'b0;
        set_loc_o  = 1'b0;
        set_lock_o = 1'b0;
        arm_clk_o  = 1'b0;
        arm_lock_o = 1'b0;
        clk_lost   = !ref_s || !fb_s;
        unique case (r_q.st)
            ST_INIT: begin
                if (ref_s && (ext_sel || lock_s))
                    r_d.st = ext_sel ? ST_EXT : ST_RUN;
            end
            ST_RUN: begin
                set_lock_o = !lock_s;
                if (clk_lost) begin
                    set_loc_o = 1'b1;
                    if (loc_rst_en) begin
                        r_d.req = 1'b1;
                        r_d.st  = ST_INIT;
                    end else if (loc_en && alt_s) begin
                        r_d.st = ST_SELF;
                    end else begin
                        r_d.st = ST_HALT;
                    end
                end else if (!lock_s && loc_rst_en) begin
                    r_d.req = 1'b1;
                    r_d.st  = ST_INIT;
                end else if (stop_req) begin
                    r_d.st = ST_STOP;
                end
            end
            ST_STOP: begin
                if (wake) begin
                    r_d.st  = ST_WAKE;
                    r_d.cnt = '0;
                end
            end
            ST_WAKE: begin
                if (ref_s && fb_s && lock_s) begin
                    r_d.st = ST_RUN;
                end else if (r_q.cnt == LIMIT) begin
                    if (!fb_s || !alt_s) begin
                        r_d.st = ST_HALT;
                    end else begin
                        set_loc_o  = !ref_s;
                        set_lock_o = !lock_s;
                        arm_clk_o  = !ref_s;
                        arm_lock_o = !lock_s;
                        r_d.st     = ST_SELF;
                    end
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: ; // ST_EXT, ST_SELF, ST_HALT hold until reset
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st  <= ST_INIT;
            r_q.cnt <= '0;
            r_q.req <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o   = r_q.st;
    assign rst_req_o = r_q.req;

endmodule

// File: rtl/clk_sup_flags.sv
module clk_sup_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic set_loc,
    input  logic set_lock,
    input  logic clr_loc,
    input  logic clr_lock,
    input  logic arm_clk,
    input  logic arm_lock,
    input  logic ref_s,
    input  logic lock_s,
    input  logic blank,
    output logic loc_flag_o,
    output logic lock_flag_o
);

    typedef struct packed {
        logic loc;
        logic lock;
        logic hold_clk;
        logic hold_lock;
    } flag_t;

    flag_t f_d, f_q;

    always_comb begin
        f_d.loc       = set_loc  | (f_q.loc  & ~clr_loc);
        f_d.lock      = set_lock | (f_q.lock & ~clr_lock);
        f_d.hold_clk  = arm_clk  | (f_q.hold_clk  & ~ref_s);
        f_d.hold_lock = arm_lock | (f_q.hold_lock & ~lock_s);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign loc_flag_o  = f_q.loc  & ~f_q.hold_clk  & ~blank;
    assign lock_flag_o = f_q.lock & ~f_q.hold_lock & ~blank;

endmodule

// File: rtl/clk_loss_supervisor.sv
module clk_loss_supervisor
    import clk_sup_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int WAKE_WAIT   = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_ok_i,
    input  logic       fb_ok_i,
    input  logic       lock_i,
    input  logic       alt_ok_i,
    input  logic       ext_sel_i,
    input  logic       loc_en_i,
    input  logic       loc_rst_en_i,
    input  logic       stop_req_i,
    input  logic       wake_i,
    input  logic       clr_loc_i,
    input  logic       clr_lock_i,
    output logic [1:0] mode_o,
    output logic       clk_gate_o,
    output logic       rst_hold_o,
    output logic       rst_req_o,
    output logic       loc_flag_o,
    output logic       lock_flag_o
);

    localparam int NDET = 4;

    logic [NDET-1:0] det_s;
    logic            ref_s, fb_s, lock_s, alt_s;
    state_e          st;
    logic            set_loc, set_lock, arm_clk, arm_lock;
    mode_e           mode_sel;

    clk_sup_sync #(.WIDTH(NDET), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({alt_ok_i, lock_i, fb_ok_i, ref_ok_i}),
        .q_o   (det_s)
    );

    assign ref_s  = det_s[0];
    assign fb_s   = det_s[1];
    assign lock_s = det_s[2];
    assign alt_s  = det_s[3];

    clk_sup_ctrl #(.WAKE_WAIT(WAKE_WAIT)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_s      (ref_s),
        .fb_s       (fb_s),
        .lock_s     (lock_s),
        .alt_s      (alt_s),
        .ext_sel    (ext_sel_i),
        .loc_en     (loc_en_i),
        .loc_rst_en (loc_rst_en_i),
        .stop_req   (stop_req_i),
        .wake       (wake_i),
        .state_o    (st),
        .rst_req_o  (rst_req_o),
        .set_loc_o  (set_loc),
        .set_lock_o (set_lock),
        .arm_clk_o  (arm_clk),
        .arm_lock_o (arm_lock)
    );

    clk_sup_flags u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_loc     (set_loc),
        .set_lock    (set_lock),
        .clr_loc     (clr_loc_i),
        .clr_lock    (clr_lock_i),
        .arm_clk     (arm_clk),
        .arm_lock    (arm_lock),
        .ref_s       (ref_s),
        .lock_s      (lock_s),
        .blank       (st == ST_EXT),
        .loc_flag_o  (loc_flag_o),
        .lock_flag_o (lock_flag_o)
    );

    always_comb begin
        unique case (st)
            ST_INIT: mode_sel = ext_sel_i ? MODE_EXT : MODE_PLL;
            ST_EXT:  mode_sel = MODE_EXT;
            ST_SELF: mode_sel = MODE_SELF;
            ST_HALT: mode_sel = MODE_HALT;
            default: mode_sel = MODE_PLL;
        endcase
    end

    assign mode_o     = mode_sel;
    assign rst_hold_o = (st == ST_INIT);
    assign clk_gate_o = (st == ST_EXT) || (st == ST_RUN) || (st == ST_SELF);

endmodule

// File: rtl/clk_loss_supervisor_chk.sv
module clk_loss_supervisor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_o,
    input logic       clk_gate_o,
    input logic       rst_hold_o,
    input logic       rst_req_o,
    input logic       loc_flag_o,
    input logic       lock_flag_o,
    input logic       ref_s,
    input logic       lock_s
);

    p_hold_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rst_hold_o |-> !clk_gate_o);

    p_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rst_hold_o) && mode_o == 2'b01) |-> ($past(ref_s) && $past(lock_s)));

    p_self_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b10) |=> (mode_o == 2'b10));

    p_halt_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b11) |=> (mode_o == 2'b11 && !clk_gate_o));

    p_req_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> !rst_req_o);

    p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> rst_hold_o);

    p_ext_blank_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b00 && !rst_hold_o) |-> (!loc_flag_o && !lock_flag_o));

endmodule

bind clk_loss_supervisor clk_loss_supervisor_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_o      (mode_o),
    .clk_gate_o  (clk_gate_o),
    .rst_hold_o  (rst_hold_o),
    .rst_req_o   (rst_req_o),
    .loc_flag_o  (loc_flag_o),
    .lock_flag_o (lock_flag_o),
    .ref_s       (ref_s),
    .lock_s      (lock_s)
);

// File: tb/clk_loss_supervisor_bench.sv
module clk_loss_supervisor_bench;

    localparam int WAKE_WAIT = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_ok = 1'b0, fb_ok = 1'b0, lock_ok = 1'b0, alt_ok = 1'b0;
    logic       ext_sel = 1'b0, loc_en = 1'b1, loc_rst_en = 1'b0;
    logic       stop_req = 1'b0, wake = 1'b0, clr_loc = 1'b0, clr_lock = 1'b0;
    logic [1:0] mode;
    logic       gate, hold, req, loc_f, lock_f;

    int n_tests = 0;
    int n_fail  = 0;
    int req_cnt = 0;

    typedef struct {
        logic [1:0] mode;
        logic       gate;
        logic       hold;
        logic       loc;
        logic       lock;
        string      tag;
    } exp_t;

    exp_t sb_q[$];

    always #10 clk = ~clk;

    clk_loss_supervisor #(.WAKE_WAIT(WAKE_WAIT)) u_clk_loss_supervisor (
        .clk          (clk),
        .rst_n        (rst_n),
        .ref_ok_i     (ref_ok),
        .fb_ok_i      (fb_ok),
        .lock_i       (lock_ok),
        .alt_ok_i     (alt_ok),
        .ext_sel_i    (ext_sel),
        .loc_en_i     (loc_en),
        .loc_rst_en_i (loc_rst_en),
        .stop_req_i   (stop_req),
        .wake_i       (wake),
        .clr_loc_i    (clr_loc),
        .clr_lock_i   (clr_lock),
        .mode_o       (mode),
        .clk_gate_o   (gate),
        .rst_hold_o   (hold),
        .rst_req_o    (req),
        .loc_flag_o   (loc_f),
        .lock_flag_o  (lock_f)
    );

    // monitor: samples mid low phase, pops and compares queued expectations
    always @(negedge clk) begin
        #5;
        if (req) req_cnt++;
        while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_tests++;
            if ({mode, gate, hold, loc_f, lock_f} !== {e.mode, e.gate, e.hold, e.loc, e.lock}) begin
                n_fail++;
                $display("FAIL %s: {mode,gate,hold,loc,lock} actual=%b_%b%b%b%b expected=%b_%b%b%b%b",
                         e.tag, mode, gate, hold, loc_f, lock_f,
                         e.mode, e.gate, e.hold, e.loc, e.lock);
            end
        end
    end

    task automatic expect_out(input logic [1:0] m, input logic g, input logic h,
                              input logic lc, input logic lk, input string tag);
        exp_t e;
        e.mode = m; e.gate = g; e.hold = h; e.loc = lc; e.lock = lk; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic check_val(input int act, input int exp, input string tag);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(ref logic sig);
        sig = 1'b1;
        @(negedge clk);
        sig = 1'b0;
    endtask

    task automatic restart(input logic ext);
        @(negedge clk);
        rst_n = 1'b0;
        ref_ok = 1'b1; fb_ok = 1'b1; lock_ok = 1'b1; alt_ok = 1'b1;
        ext_sel = ext; loc_en = 1'b1; loc_rst_en = 1'b0;
        stop_req = 1'b0; wake = 1'b0; clr_loc = 1'b0; clr_lock = 1'b0;
        settle(3);
        rst_n = 1'b1;
        settle(5);
    endtask

    initial begin
        int base;
        // R1 R2: reset state with all detectors absent
        settle(2);
        expect_out(2'b01, 1'b0, 1'b1, 1'b0, 1'b0, "R1 R2 in reset");
        settle(2);
        rst_n = 1'b1;
        settle(5);
        expect_out(2'b01, 1'b0, 1'b1, 1'b0, 1'b0, "R1 no detectors");
        ref_ok = 1'b1;
        settle(5);
        expect_out(2'b01, 1'b0, 1'b1, 1'b0, 1'b0, "R1 reference without lock");
        lock_ok = 1'b1; fb_ok = 1'b1; alt_ok = 1'b1;
        settle(5);
        expect_out(2'b01, 1'b1, 1'b0, 1'b0, 1'b0, "R1 release");

        // R7: lock loss only
        lock_ok = 1'b0;
        settle(5);
        expect_out(2'b01, 1'b1, 1'b0, 1'b0, 1'b1, "R7 lock loss");
        lock_ok = 1'b1;
        settle(5);
        expect_out(2'b01, 1'b1, 1'b0, 1'b0, 1'b1, "R8 sticky");
        // R8: clear collides with a live set condition
        lock_ok = 1'b0;
        settle(5);
        pulse(clr_lock);
        settle(2);
        expect_out(2'b01, 1'b1, 1'b0, 1'b0, 1'b1, "R8 set wins over clear");
        lock_ok = 1'b1;
        settle(5);
        pulse(clr_lock);
        settle(1);
        expect_out(2'b01, 1'b1, 1'b0, 1'b0, 1'b0, "R8 clear");

        // R3 R14: both clocks lost with a stop request in the same controller cycle
        ref_ok = 1'b0; fb_ok = 1'b0;
        settle(2);
        pulse(stop_req);
        settle(3);
        expect_out(2'b10, 1'b1, 1'b0, 1'b1, 1'b0, "R3 R14 fallback");
        ref_ok = 1'b1; fb_ok = 1'b1;
        settle(6);
        expect_out(2'b10, 1'b1, 1'b0, 1'b1, 1'b0, "R4 stays self-clocked");

        // R5: fallback oscillator dead
        restart(1'b0);
        alt_ok = 1'b0; ref_ok = 1'b0;
        settle(5);
        expect_out(2'b11, 1'b0, 1'b0, 1'b1, 1'b0, "R5 halt no fallback");
        ref_ok = 1'b1; alt_ok = 1'b1;
        settle(5);
        expect_out(2'b11, 1'b0, 1'b0, 1'b1, 1'b0, "R5 halt persists");

        // R5: loss enable off
        restart(1'b0);
        loc_en = 1'b0; fb_ok = 1'b0;
        settle(5);
        expect_out(2'b11, 1'b0, 1'b0, 1'b1, 1'b0, "R5 halt loc_en=0");

        // R6: reset on loss
        restart(1'b0);
        loc_rst_en = 1'b1;
        base = req_cnt;
        ref_ok = 1'b0;
        settle(6);
        expect_out(2'b01, 1'b0, 1'b1, 1'b1, 1'b0, "R6 back to hold");
        settle(1);
        check_val(req_cnt - base, 1, "R6 request width");
        ref_ok = 1'b1;
        settle(5);
        expect_out(2'b01, 1'b1, 1'b0, 1'b1, 1'b0, "R6 release again");

        // R9: external clock mode
        restart(1'b1);
        expect_out(2'b00, 1'b1, 1'b0, 1'b0, 1'b0, "R9 R2 external run");
        ref_ok = 1'b0; fb_ok = 1'b0; lock_ok = 1'b0;
        settle(6);
        expect_out(2'b00, 1'b1, 1'b0, 1'b0, 1'b0, "R9 losses ignored");

        // R10: stop, ignored disturbance, clean wake
        restart(1'b0);
        pulse(stop_req);
        settle(2);
        expect_out(2'b01, 1'b0, 1'b0, 1'b0, 1'b0, "R10 stopped");
        lock_ok = 1'b0; ref_ok = 1'b0;
        settle(5);
        lock_ok = 1'b1; ref_ok = 1'b1;
        settle(5);
        expect_out(2'b01, 1'b0, 1'b0, 1'b0, 1'b0, "R10 stop ignores losses");
        pulse(wake);
        settle(3);
        expect_out(2'b01, 1'b1, 1'b0, 1'b0, 1'b0, "R10 wake to PLL");

        // R11 R12: lock does not return
        restart(1'b0);
        pulse(stop_req);
        lock_ok = 1'b0;
        settle(3);
        pulse(wake);
        settle(WAKE_WAIT + 8);
        expect_out(2'b10, 1'b1, 1'b0, 1'b0, 1'b0, "R11 R12 lock flag held off");
        lock_ok = 1'b1;
        settle(5);
        expect_out(2'b10, 1'b1, 1'b0, 1'b0, 1'b1, "R12 lock flag shown");

        // R11 R12: reference does not return, loss enable off
        restart(1'b0);
        loc_en = 1'b0;
        pulse(stop_req);
        ref_ok = 1'b0;
        settle(3);
        pulse(wake);
        settle(WAKE_WAIT + 8);
        expect_out(2'b10, 1'b1, 1'b0, 1'b0, 1'b0, "R11 R12 loss flag held off");
        ref_ok = 1'b1;
        settle(5);
        expect_out(2'b10, 1'b1, 1'b0, 1'b1, 1'b0, "R12 loss flag shown");

        // R13: feedback does not return
        restart(1'b0);
        pulse(stop_req);
        fb_ok = 1'b0;
        settle(3);
        pulse(wake);
        settle(WAKE_WAIT + 8);
        expect_out(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, "R13 halt on wake");

        settle(3);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule